// File: doc/BRIEF.md
# Prescaled Interval Timer with Tap Select

The block counts ticks of one of two clock sources in a 14-bit prescaler. It turns the rising edge of one prescaler stage into a one-cycle interval event. The two sources are a fast system tick and a slow sub-clock tick, both modelled as clock enables in the `clk_i` domain. A 3-bit code picks the stage from a sparse set of eight. A bypass bit skips the prescaler, so every source tick becomes an event. A mode bit sends each event either to an interrupt request line or to a timer output line.

Software drives the block through one control write. The write is a strobe plus data, and it updates the tap code, the source select, the bypass bit and the routing bit. The same write can also carry a restart bit, which clears the prescaler to zero. The prescaler never waits for software: it counts from reset onwards. Every stage of the prescaler is also driven out on a vector, so that a neighbouring watchdog can tap its own stages.

Top module: `interval_timer`

## Requirements
- R1: While `rst_ni` is low, and right after it rises, `stage_o` is zero and `irq_o` and `tout_o` are low. All control fields reset to zero, which selects tap Q1, the system tick, bypass off and interrupt routing.
- R2: In a cycle with the selected tick high and no restart, the prescaler advances by one at the next edge, wrapping from 16383 to 0. In a cycle without a selected tick it holds its value.
- R3: Control bit 4 selects the count source: 0 selects `sys_tick_i` and 1 selects `sub_tick_i`. The tick that is not selected has no effect on `stage_o`, `irq_o` or `tout_o`.
- R4: A write with control bit 3 set clears the prescaler, so `stage_o` reads 0 in the next cycle even if a tick was present. No event is produced for that cycle. A write with bit 3 clear leaves the count running.
- R5: Control bits 2:0 select the tap. Codes 0 to 7 map to stages Q1, Q2, Q3, Q4, Q5, Q8, Q11 and Q14. For tap Qn, an event pulse appears one cycle after the tick that moves the low n bits of the count from 2^(n-1)-1 to 2^(n-1), giving one pulse every 2^n ticks.
- R6: With control bit 5 set (bypass), every selected tick in a non-restart cycle yields an event in the next cycle, whatever the tap code.
- R7: Control bit 6 routes events: 0 sends them to `irq_o` and 1 sends them to `tout_o`. The other output stays low, and the two outputs are never high together.
- R8: `stage_o[k-1]` carries prescaler stage Qk, so `stage_o` equals the count.
- R9: A write takes effect from the cycle after its strobe. The event decision in the write cycle itself uses the fields that were in force before the write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Block clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| sys_tick_i | input | 1 | System clock enable |
| sub_tick_i | input | 1 | Sub-clock enable |
| wr_i | input | 1 | Control write strobe |
| wdata_i | input | 7 | Control write data (bits 2:0 tap, 3 restart, 4 source, 5 bypass, 6 route) |
| stage_o | output | 14 | Prescaler stage outputs Q1..Q14 |
| irq_o | output | 1 | Interval interrupt request pulse |
| tout_o | output | 1 | Interval timer output pulse |

## Verification
The bench builds the block with its default 14-bit prescaler. This width lets every tap code be checked with its full period, including Q14 at 16384 ticks, and lets the count be seen wrapping at 16383, all within the run. Random tick patterns on both sources, combined with random non-restart writes, exercise source selection, bypass and routing. They also cover the rule that a write only takes effect in the cycle after it.

// File: rtl/itmr_pkg.sv
package itmr_pkg;
  localparam int CTRL_W      = 7;
  localparam int TAP_W       = 3;
  localparam int NUM_TAPS    = 1 << TAP_W;
  localparam int RESTART_BIT = 3;
  localparam int SRC_BIT     = 4;
  localparam int BYP_BIT     = 5;
  localparam int ROUTE_BIT   = 6;

  typedef struct packed {
    logic             out_mode;
    logic             bypass;
    logic             clk_sel;
    logic [TAP_W-1:0] tap_sel;
  } ctrl_t;

  // sparse code-to-stage map; clamped to the counter width
  function automatic int tap_stage(input int code, input int cnt_w);
    int s;
    case (code)
      5:       s = 8;
      6:       s = 11;
      7:       s = 14;
      default: s = code + 1;
    endcase
    return (s > cnt_w) ? cnt_w : s;
  endfunction
endpackage

// File: rtl/itmr_ctrl.sv
module itmr_ctrl
  import itmr_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic [CTRL_W-1:0] wdata_i,
  output ctrl_t             ctrl_o,
  output logic              restart_o
);
  ctrl_t ctrl_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q <= '0;
    end else if (wr_i) begin
      ctrl_q.out_mode <= wdata_i[ROUTE_BIT];
      ctrl_q.bypass   <= wdata_i[BYP_BIT];
      ctrl_q.clk_sel  <= wdata_i[SRC_BIT];
      ctrl_q.tap_sel  <= wdata_i[TAP_W-1:0];
    end
  end

  assign ctrl_o    = ctrl_q;
  assign restart_o = wr_i & wdata_i[RESTART_BIT];
endmodule

// File: rtl/itmr_prescaler.sv
module itmr_prescaler #(
  parameter int CNT_W = 14
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             sys_tick_i,
  input  logic             sub_tick_i,
  input  logic             clk_sel_i,
  input  logic             restart_i,
  output logic             tick_o,
  output logic [CNT_W-1:0] cnt_o
);
  logic [CNT_W-1:0] cnt_q;

  assign tick_o = clk_sel_i ? sub_tick_i : sys_tick_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        cnt_q <= '0;
    else if (restart_i) cnt_q <= '0;
    else if (tick_o)    cnt_q <= cnt_q + 1'b1;
  end

  assign cnt_o = cnt_q;
endmodule

// File: rtl/itmr_event.sv
module itmr_event
  import itmr_pkg::*;
#(
  parameter int CNT_W = 14
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [CNT_W-1:0] cnt_i,
  input  logic             tick_i,
  input  logic             restart_i,
  input  ctrl_t            ctrl_i,
  output logic             irq_o,
  output logic             tout_o
);
  logic [NUM_TAPS-1:0] hit;
  logic                ev_d;
  logic                irq_q, tout_q;

  // hit[g]: next tick raises stage N of tap g (low N bits = 2^(N-1)-1)
  for (genvar g = 0; g < NUM_TAPS; g++) begin : g_tap
    localparam int N = tap_stage(g, CNT_W);
    if (N == 1) begin : g_q1
      assign hit[g] = ~cnt_i[0];
    end else begin : g_qn
      assign hit[g] = ~cnt_i[N-1] & (&cnt_i[N-2:0]);
    end
  end

  assign ev_d = tick_i & ~restart_i & (ctrl_i.bypass | hit[ctrl_i.tap_sel]);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      irq_q  <= 1'b0;
      tout_q <= 1'b0;
    end else begin
      irq_q  <= ev_d & ~ctrl_i.out_mode;
      tout_q <= ev_d &  ctrl_i.out_mode;
    end
  end

  assign irq_o  = irq_q;
  assign tout_o = tout_q;
endmodule

// File: rtl/interval_timer.sv
module interval_timer
  import itmr_pkg::*;
#(
  parameter int CNT_W = 14
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sys_tick_i,
  input  logic              sub_tick_i,
  input  logic              wr_i,
  input  logic [CTRL_W-1:0] wdata_i,
  output logic [CNT_W-1:0]  stage_o,
  output logic              irq_o,
  output logic              tout_o
);
  ctrl_t            ctrl;
  logic             restart;
  logic             tick;
  logic [CNT_W-1:0] cnt;

  itmr_ctrl u_ctrl (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .wr_i     (wr_i),
    .wdata_i  (wdata_i),
    .ctrl_o   (ctrl),
    .restart_o(restart)
  );

  itmr_prescaler #(.CNT_W(CNT_W)) u_pre (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .sys_tick_i(sys_tick_i),
    .sub_tick_i(sub_tick_i),
    .clk_sel_i (ctrl.clk_sel),
    .restart_i (restart),
    .tick_o    (tick),
    .cnt_o     (cnt)
  );

  itmr_event #(.CNT_W(CNT_W)) u_evt (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .cnt_i    (cnt),
    .tick_i   (tick),
    .restart_i(restart),
    .ctrl_i   (ctrl),
    .irq_o    (irq_o),
    .tout_o   (tout_o)
  );

  assign stage_o = cnt;
endmodule

// File: rtl/interval_timer_sva.sv
module interval_timer_sva
  import itmr_pkg::*;
#(
  parameter int CNT_W = 14
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic [CNT_W-1:0] stage_o,
  input logic             irq_o,
  input logic             tout_o,
  input logic             tick,
  input logic             restart,
  input ctrl_t            ctrl
);
  assert_count_step_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick && !restart) |=> stage_o == ($past(stage_o) + 1'b1));

  assert_count_hold_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!tick && !restart) |=> $stable(stage_o));

  assert_restart_clear_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    restart |=> (stage_o == '0) && !irq_o && !tout_o);

  assert_bypass_event_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctrl.bypass && tick && !restart) |=> (irq_o || tout_o));

  assert_route_exclusive_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones({irq_o, tout_o}) <= 1);

  assert_route_irq_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> !$past(ctrl.out_mode));

  assert_route_tout_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tout_o |-> $past(ctrl.out_mode));
endmodule

bind interval_timer interval_timer_sva #(.CNT_W(CNT_W)) u_sva (
  .clk_i  (clk_i),
  .rst_ni (rst_ni),
  .stage_o(stage_o),
  .irq_o  (irq_o),
  .tout_o (tout_o),
  .tick   (tick),
  .restart(restart),
  .ctrl   (ctrl)
);

// File: tb/interval_timer_test.sv
module interval_timer_test;
  localparam int CLK_PERIOD = 10;
  localparam int CW = 14;
  localparam int MOD = 1 << CW;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          sys_tick = 1'b0, sub_tick = 1'b0, wr = 1'b0;
  logic [6:0]    wdata = '0;
  logic [CW-1:0] stage;
  logic          irq, tout;

  int checks = 0, fails = 0, cycles = 0, pulses = 0;
  bit cmp_en = 1'b0;
  string cur_req = "R1";

  // reference model state
  int m_cnt = 0;
  bit [2:0] m_sel = 0;
  bit m_cs = 0, m_byp = 0, m_mode = 0, m_irq = 0, m_tout = 0;

  interval_timer uut (
    .clk_i(clk), .rst_ni(rst_n), .sys_tick_i(sys_tick), .sub_tick_i(sub_tick),
    .wr_i(wr), .wdata_i(wdata), .stage_o(stage), .irq_o(irq), .tout_o(tout)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic int stage_of(input int code);
    int t[8] = '{1, 2, 3, 4, 5, 8, 11, 14};
    return t[code];
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", req, act, exp, $time);
    end
  endtask

  // model step on each edge (inputs change at negedge only)
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_cnt = 0; m_sel = 0; m_cs = 0; m_byp = 0; m_mode = 0; m_irq = 0; m_tout = 0;
    end else begin
      bit tk, rs, ev;
      int n;
      tk = m_cs ? sub_tick : sys_tick;
      rs = wr && wdata[3];
      n  = stage_of(m_sel);
      ev = 0;
      if (tk && !rs) ev = m_byp ? 1'b1 : ((m_cnt % (1 << n)) == ((1 << (n-1)) - 1));
      m_irq  = ev && !m_mode;
      m_tout = ev && m_mode;
      if (rs) m_cnt = 0;
      else if (tk) m_cnt = (m_cnt + 1) % MOD;
      if (wr) begin
        m_sel = wdata[2:0]; m_cs = wdata[4]; m_byp = wdata[5]; m_mode = wdata[6];
      end
    end
  end

  always @(negedge clk) begin
    if (cmp_en && rst_n) begin
      chk(stage == m_cnt[CW-1:0], {cur_req, "/R8 stage"}, stage, m_cnt);
      chk(irq == m_irq, {cur_req, " irq"}, irq, m_irq);
      chk(tout == m_tout, {cur_req, " tout"}, tout, m_tout);
      if (irq) pulses++;
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 190000) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr_ctrl(input logic [6:0] d);
    wr = 1'b1; wdata = d;
    @(negedge clk);
    wr = 1'b0;
  endtask

  initial begin
    step(3);
    // R1: reset state
    chk(stage == 0, "R1 stage in reset", stage, 0);
    chk(!irq && !tout, "R1 outputs in reset", {irq, tout}, 0);
    rst_n = 1'b1;
    cmp_en = 1'b1;
    step(1);
    chk(stage == 0 && !irq && !tout, "R1 after release", stage, 0);

    // R2: free run from reset, no software action, Q1 default
    cur_req = "R2";
    sys_tick = 1'b1;
    step(20);
    chk(stage == 20, "R2 count after 20 ticks", stage, 20);

    // R5: each tap code gives two pulses in 2^(n+1) ticks after restart
    cur_req = "R5";
    for (int c = 0; c < 8; c++) begin
      int n;
      n = stage_of(c);
      wr_ctrl(7'h08 | 7'(c));
      pulses = 0;
      step(1 << (n + 1));
      #1;
      chk(pulses == 2, $sformatf("R5 pulses code %0d", c), pulses, 2);
    end

    // R2: wrap at 16383
    cur_req = "R2";
    wr_ctrl(7'h0F);
    step(MOD - 1);
    chk(stage == MOD - 1, "R2 top count", stage, MOD - 1);
    step(1);
    chk(stage == 0, "R2 wrap to zero", stage, 0);

    // R4: restart mid-count with tick present; non-restart write keeps counting
    cur_req = "R4";
    wr_ctrl(7'h08);
    step(37);
    chk(stage == 37, "R8 count after 37 ticks", stage, 37);
    wr_ctrl(7'h02);
    chk(stage == 38, "R4 no-restart write keeps count", stage, 38);
    wr_ctrl(7'h0A);
    chk(stage == 0, "R4 restart with tick", stage, 0);

    // R3: sub-clock selected, system tick toggling
    cur_req = "R3";
    wr_ctrl(7'h18);
    sys_tick = 1'b1; sub_tick = 1'b0;
    step(10);
    chk(stage == 0, "R3 unselected tick ignored", stage, 0);
    for (int i = 0; i < 300; i++) begin
      sys_tick = 1'($urandom); sub_tick = 1'($urandom);
      step(1);
    end

    // R6: bypass with random ticks, both sources
    cur_req = "R6";
    wr_ctrl(7'h27);
    for (int i = 0; i < 200; i++) begin
      sys_tick = 1'($urandom); sub_tick = 1'($urandom);
      step(1);
    end

    // R7: route to timer output
    cur_req = "R7";
    wr_ctrl(7'h68);
    sys_tick = 1'b1;
    step(1);
    chk(tout == 1 && irq == 0, "R7 bypass event on tout", {irq, tout}, 1);
    wr_ctrl(7'h41);
    for (int i = 0; i < 200; i++) begin
      sys_tick = 1'($urandom);
      step(1);
    end

    // R9: random non-restart writes mixed with random ticks
    cur_req = "R9";
    for (int i = 0; i < 1500; i++) begin
      sys_tick = 1'($urandom); sub_tick = 1'($urandom);
      if (i % 23 == 0) wr_ctrl(7'($urandom) & 7'h77);
      else step(1);
    end

    cmp_en = 1'b0;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule